// File: doc/BRIEF.md
# Instruction Fetch Address-Match Patcher

This block sits between the instruction memory and the decoder of a small CPU with a 24-bit byte address space. It holds a configurable number of detect slots (two by default). Each slot has a 24-bit byte address and its own enable bit. When the CPU fetches a byte whose address equals an enabled slot address, the block replaces that byte with a fixed software-interrupt opcode (0x01). The address must also lie inside the internal ROM window. The interrupt handler can then run patch code in place of faulty ROM code. The substitution is purely combinational, so the fetch path takes no extra cycle.

Software configures the block over a simple byte-wide register bus. Every slot address is written one byte at a time. A shared control register holds the enables. A sticky status register records which slot has fired, and software clears it by writing ones. Software has to disable a slot before it rewrites that slot's address bytes. The block does nothing to prevent a compare against a half-written address.

Top module: `fetch_patch_unit`

## Requirements
- R1: After reset, all slot address bytes, the enable bits and the status bits are zero, and every register reads back as 0x00.
- R2: The register offsets are as follows. Slot n, byte k (k=0 low, 1 middle, 2 high/bank) sits at offset 4*n+k. The control register is at offset 4*NUM_DET, with bit n enabling slot n. The status register is at offset 4*NUM_DET+1. A write takes effect at the next rising clock edge. `reg_rdata` returns the current contents combinationally, and unmapped offsets read 0x00.
- R3: A valid fetch qualifies when its address equals the address of an enabled slot and lies inside the ROM window. On a qualifying fetch, `fetch_data_out` is 0x01 in the same cycle.
- R4: Whenever no substitution takes place, `fetch_data_out` equals `fetch_data_in`.
- R5: A slot whose enable bit is 0 never causes a substitution.
- R6: An address outside the ROM window [ROM_LO, ROM_HI] (default 0xFF0000 to 0xFFFFFF, compared on all 24 bits) never causes a substitution, even when it equals an enabled slot address.
- R7: The compare uses the exact byte address, at any alignment. Neighbouring addresses (slot address -1 and +1) are not substituted. No instruction-boundary check is made.
- R8: When several enabled slots hit the same fetch, the output is still the single value 0x01, and the status bit of every slot that hit is set.
- R9: Status bit n is set on the clock edge after a substituting fetch hits slot n. It stays set until software writes a 1 to that bit. If a hit and a clear fall in the same cycle, the hit wins.
- R10: `patch_hit` is high in exactly the cycles in which the fetch byte is substituted.
- R11: When `fetch_valid` is low, no substitution takes place and no status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write byte |
| reg_rdata | output | 8 | Register read byte (combinational) |
| fetch_valid | input | 1 | Fetch byte is valid this cycle |
| fetch_addr | input | 24 | Byte address of the fetch |
| fetch_data_in | input | 8 | Byte from instruction memory |
| fetch_data_out | output | 8 | Byte delivered to the decoder |
| patch_hit | output | 1 | High when the byte is substituted |

## Verification
The bench targets the byte-exact compare. It fetches the bytes just before and just after an unaligned slot address. A design that masked low address bits, or that patched the whole instruction, would corrupt those neighbouring bytes. It sets a slot to an address outside the ROM window, where a missing window check would inject a trap into external code. It points both slots at one address and also clears status in the same cycle as a hit. A wrong priority in either case would lose a status bit or produce something other than 0x01. It also drops `fetch_valid` on a matching address: an ungated compare would patch idle bus values and set status falsely.

// File: rtl/fpu_pkg.sv
package fpu_pkg;
  localparam logic [7:0] TRAP_OPCODE = 8'h01;
  localparam int SLOT_STRIDE = 4;

  function automatic logic addr_in_window(input logic [31:0] a,
                                          input logic [31:0] lo,
                                          input logic [31:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  function automatic int slot_byte_offset(input int slot, input int byte_idx);
    return slot * SLOT_STRIDE + byte_idx;
  endfunction
endpackage

// File: rtl/fpu_regs.sv
module fpu_regs #(
  parameter int NUM_DET = 2,
  parameter int ADDR_W  = 24,
  parameter int REG_AW  = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            reg_we,
  input  logic [REG_AW-1:0]               reg_addr,
  input  logic [7:0]                      reg_wdata,
  output logic [7:0]                      reg_rdata,
  input  logic [NUM_DET-1:0]              hit_vec,
  output logic [NUM_DET-1:0][ADDR_W-1:0]  det_addr,
  output logic [NUM_DET-1:0]              en_vec,
  output logic [NUM_DET-1:0]              stat_vec
);
  import fpu_pkg::*;
  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int CTRL_OFS   = SLOT_STRIDE * NUM_DET;
  localparam int STAT_OFS   = CTRL_OFS + 1;

  logic ctrl_wr, stat_wr;
  logic [NUM_DET-1:0] clr_vec;

  assign ctrl_wr = reg_we && (reg_addr == REG_AW'(CTRL_OFS));
  assign stat_wr = reg_we && (reg_addr == REG_AW'(STAT_OFS));
  assign clr_vec = stat_wr ? reg_wdata[NUM_DET-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det_addr <= '0;
      en_vec   <= '0;
      stat_vec <= '0;
    end else begin
      for (int i = 0; i < NUM_DET; i++) begin
        for (int b = 0; b < ADDR_BYTES; b++) begin
          if (reg_we && (reg_addr == REG_AW'(slot_byte_offset(i, b))))
            det_addr[i][b*8 +: 8] <= reg_wdata;
        end
      end
      if (ctrl_wr) en_vec <= reg_wdata[NUM_DET-1:0];
      stat_vec <= (stat_vec & ~clr_vec) | hit_vec;
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    for (int i = 0; i < NUM_DET; i++) begin
      for (int b = 0; b < ADDR_BYTES; b++) begin
        if (reg_addr == REG_AW'(slot_byte_offset(i, b)))
          reg_rdata = det_addr[i][b*8 +: 8];
      end
    end
    if (reg_addr == REG_AW'(CTRL_OFS)) reg_rdata = 8'(en_vec);
    if (reg_addr == REG_AW'(STAT_OFS)) reg_rdata = 8'(stat_vec);
  end
endmodule

// File: rtl/fpu_match.sv
module fpu_match #(
  parameter int ADDR_W = 24
) (
  input  logic              fetch_valid,
  input  logic              rom_ok,
  input  logic              enable,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic [ADDR_W-1:0] det_addr,
  output logic              hit
);
  logic addr_eq;
  assign addr_eq = (fetch_addr == det_addr);
  assign hit     = fetch_valid && rom_ok && enable && addr_eq;
endmodule

// File: rtl/fpu_subst.sv
module fpu_subst #(
  parameter int NUM_DET = 2
) (
  input  logic [NUM_DET-1:0] hit_vec,
  input  logic [7:0]         data_in,
  output logic [7:0]         data_out,
  output logic               any_hit
);
  import fpu_pkg::*;
  assign any_hit  = |hit_vec;
  assign data_out = any_hit ? TRAP_OPCODE : data_in;
endmodule

// File: rtl/fetch_patch_unit.sv
module fetch_patch_unit #(
  parameter int          NUM_DET = 2,
  parameter int          ADDR_W  = 24,
  parameter int          REG_AW  = 4,
  parameter logic [23:0] ROM_LO  = 24'hFF0000,
  parameter logic [23:0] ROM_HI  = 24'hFFFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic [7:0]        fetch_data_in,
  output logic [7:0]        fetch_data_out,
  output logic              patch_hit
);
  import fpu_pkg::*;

  logic [NUM_DET-1:0][ADDR_W-1:0] det_addr;
  logic [NUM_DET-1:0]             en_vec;
  logic [NUM_DET-1:0]             stat_vec;
  logic [NUM_DET-1:0]             hit_vec;
  logic                           rom_ok;

  assign rom_ok = addr_in_window(32'(fetch_addr), 32'(ROM_LO), 32'(ROM_HI));

  fpu_regs #(.NUM_DET(NUM_DET), .ADDR_W(ADDR_W), .REG_AW(REG_AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hit_vec(hit_vec),
    .det_addr(det_addr), .en_vec(en_vec), .stat_vec(stat_vec)
  );

  for (genvar g = 0; g < NUM_DET; g++) begin : g_slot
    fpu_match #(.ADDR_W(ADDR_W)) u_match (
      .fetch_valid(fetch_valid), .rom_ok(rom_ok), .enable(en_vec[g]),
      .fetch_addr(fetch_addr), .det_addr(det_addr[g]), .hit(hit_vec[g])
    );
  end

  fpu_subst #(.NUM_DET(NUM_DET)) u_subst (
    .hit_vec(hit_vec), .data_in(fetch_data_in),
    .data_out(fetch_data_out), .any_hit(patch_hit)
  );
endmodule

// File: rtl/fpu_checker.sv
module fpu_checker #(
  parameter int          NUM_DET = 2,
  parameter int          ADDR_W  = 24,
  parameter int          REG_AW  = 4,
  parameter logic [23:0] ROM_LO  = 24'hFF0000,
  parameter logic [23:0] ROM_HI  = 24'hFFFFFF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [REG_AW-1:0] reg_addr,
  input logic [7:0]        reg_wdata,
  input logic              fetch_valid,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic [7:0]        fetch_data_in,
  input logic [7:0]        fetch_data_out,
  input logic              patch_hit,
  input logic [NUM_DET-1:0] hit_vec,
  input logic [NUM_DET-1:0] en_vec,
  input logic [NUM_DET-1:0] stat_vec
);
  localparam int STAT_OFS = 4 * NUM_DET + 1;

  assert_trap_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
    patch_hit |-> fetch_data_out == 8'h01);

  assert_passthrough_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !patch_hit |-> fetch_data_out == fetch_data_in);

  assert_rom_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_addr < ROM_LO || fetch_addr > ROM_HI) |-> !patch_hit);

  assert_hit_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit_vec) |-> patch_hit);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |-> !patch_hit);

  for (genvar g = 0; g < NUM_DET; g++) begin : g_chk
    assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !en_vec[g] |-> !hit_vec[g]);

    assert_status_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      hit_vec[g] |=> stat_vec[g]);

    assert_status_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_vec[g] && !(reg_we && reg_addr == REG_AW'(STAT_OFS) && reg_wdata[g]))
      |=> stat_vec[g]);
  end
endmodule

bind fetch_patch_unit fpu_checker #(
  .NUM_DET(NUM_DET), .ADDR_W(ADDR_W), .REG_AW(REG_AW),
  .ROM_LO(ROM_LO), .ROM_HI(ROM_HI)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
  .fetch_data_in(fetch_data_in), .fetch_data_out(fetch_data_out),
  .patch_hit(patch_hit), .hit_vec(hit_vec), .en_vec(en_vec), .stat_vec(stat_vec)
);

// File: tb/fetch_patch_unit_test.sv
`timescale 1ns/1ps
module fetch_patch_unit_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_we = 0;
  logic [3:0]  reg_addr = 0;
  logic [7:0]  reg_wdata = 0;
  logic [7:0]  reg_rdata;
  logic        fetch_valid = 0;
  logic [23:0] fetch_addr = 0;
  logic [7:0]  fetch_data_in = 0;
  logic [7:0]  fetch_data_out;
  logic        patch_hit;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // behavioural reference state
  int m_det [2];
  int m_en;
  int m_stat;

  always #2 clk = ~clk;

  fetch_patch_unit uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fetch_valid(fetch_valid),
    .fetch_addr(fetch_addr), .fetch_data_in(fetch_data_in),
    .fetch_data_out(fetch_data_out), .patch_hit(patch_hit)
  );

  function automatic int slot_hits();
    int r = 0;
    int a = int'(fetch_addr);
    if (!fetch_valid) return 0;
    if (a < 'hFF0000 || a > 'hFFFFFF) return 0;
    for (int i = 0; i < 2; i++)
      if (((m_en >> i) & 1) == 1 && m_det[i] == a) r |= (1 << i);
    return r;
  endfunction

  function automatic int exp_rdata();
    int o = int'(reg_addr);
    if (o == 8) return m_en;
    if (o == 9) return m_stat;
    for (int i = 0; i < 2; i++)
      for (int b = 0; b < 3; b++)
        if (o == i * 4 + b) return (m_det[i] >> (8 * b)) & 'hFF;
    return 0;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // compare outputs mid-cycle, then advance one clock and update the model
  task automatic step(string tag);
    int h;
    #1;
    h = slot_hits();
    check(tag, "fetch_data_out", int'(fetch_data_out),
          (h != 0) ? 1 : int'(fetch_data_in));
    check(tag, "patch_hit", int'(patch_hit), (h != 0) ? 1 : 0);
    check(tag, "reg_rdata", int'(reg_rdata), exp_rdata());
    @(posedge clk);
    if (reg_we) begin
      int o = int'(reg_addr);
      for (int i = 0; i < 2; i++)
        for (int b = 0; b < 3; b++)
          if (o == i * 4 + b)
            m_det[i] = (m_det[i] & ~('hFF << (8 * b))) | (int'(reg_wdata) << (8 * b));
      if (o == 8) m_en = int'(reg_wdata) & 3;
      if (o == 9) m_stat = m_stat & ~(int'(reg_wdata) & 3);
    end
    m_stat = m_stat | h;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic wr(int off, int val, string tag);
    reg_we = 1; reg_addr = 4'(off); reg_wdata = 8'(val);
    step(tag);
  endtask

  task automatic rd(int off, string tag);
    reg_we = 0; reg_addr = 4'(off);
    step(tag);
  endtask

  task automatic set_slot(int s, int a, string tag);
    for (int b = 0; b < 3; b++) wr(s * 4 + b, (a >> (8 * b)) & 'hFF, tag);
  endtask

  task automatic fetch(int a, int d, string tag);
    fetch_valid = 1; fetch_addr = 24'(a); fetch_data_in = 8'(d);
    step(tag);
    fetch_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    m_det[0] = 0; m_det[1] = 0; m_en = 0; m_stat = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset values on every offset
    for (int o = 0; o < 16; o++) rd(o, "R1");
    fetch('hFF0000, 'h5A, "R1");

    // R2: layout and read-back
    set_slot(0, 'hFF001F, "R2");
    set_slot(1, 'hFF0040, "R2");
    for (int o = 0; o < 10; o++) rd(o, "R2");

    // R5: disabled slots do nothing
    fetch('hFF001F, 'hA5, "R5");
    fetch('hFF0040, 'h3C, "R5");
    rd(9, "R5");

    // R3, R7: enable slot 0, fetch around an unaligned address
    wr(8, 1, "R2");
    for (int a = 'hFF001C; a <= 'hFF0021; a++) fetch(a, 'h4A, "R7");
    fetch('hFF001F, 'h80, "R3");
    fetch('hFF0040, 'h08, "R5");
    rd(9, "R9");

    // R11: idle bus on matching address
    wr(9, 1, "R9");
    rd(9, "R9");
    fetch_valid = 0; fetch_addr = 24'hFF001F; fetch_data_in = 8'h77;
    step("R11");
    rd(9, "R11");

    // R4: passthrough across data values
    for (int d = 0; d < 256; d += 17) fetch('hFF1000 + d, d, "R4");

    // R6: outside the ROM window
    wr(8, 0, "R6");
    set_slot(0, 'h00001F, "R6");
    wr(8, 1, "R6");
    fetch('h00001F, 'hC3, "R6");
    fetch('hFEFFFF, 'hC3, "R6");
    rd(9, "R6");
    wr(8, 0, "R6");
    set_slot(0, 'hFF0000, "R6");
    wr(8, 1, "R6");
    fetch('hFF0000, 'h11, "R6");

    // R8: both slots on one address
    wr(8, 0, "R8");
    wr(9, 3, "R8");
    set_slot(0, 'hFFFFFF, "R8");
    set_slot(1, 'hFFFFFF, "R8");
    wr(8, 3, "R8");
    fetch('hFFFFFF, 'h99, "R8");
    rd(9, "R8");

    // R9: hit and clear in the same cycle, hit wins
    reg_we = 1; reg_addr = 4'd9; reg_wdata = 8'h03;
    fetch_valid = 1; fetch_addr = 24'hFFFFFF; fetch_data_in = 8'h42;
    step("R9");
    fetch_valid = 0;
    rd(9, "R9");
    wr(9, 2, "R9");
    rd(9, "R9");

    // R10: mixed traffic
    wr(8, 0, "R10");
    set_slot(1, 'hFF2345, "R10");
    wr(8, 2, "R10");
    for (int k = 0; k < 300; k++) begin
      fetch_valid = ((k % 5) != 0);
      fetch_addr = 24'('hFF2340 + (k * 7) % 11);
      fetch_data_in = 8'(k * 13);
      reg_addr = 4'(k % 10);
      step("R10");
    end
    fetch_valid = 0;
    rd(9, "R10");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule